// File: doc/BRIEF.md
# Polling Command/Response Transaction Sequencer

This block is a host-side bus master. It runs one full command/response exchange with a byte-addressed device register window, using single-byte reads and writes. A start pulse launches the exchange. The command bytes come from a local buffer, which the sequencer addresses itself. The caller supplies the command length and the capacity of the response buffer. The sequencer checks that the device is present, claims ownership, puts the device in its ready state, streams the command in burst-sized chunks, and starts execution. It then reads and checks the response header and copies the response into the local buffer.

Every wait on a device status bit is a poll with a bound. A failed check is followed by a fixed interval of `POLL_US` microseconds, counted from a clock-to-microsecond divide of `TICK_DIV` cycles. After `ceil(timeout/POLL_US)` failed reads the phase gives up. Each phase has its own timeout parameter. Whatever the outcome, the exchange finishes by writing the ready bit to the status register, and then raises a one-cycle done pulse with a result code.

Result codes: 0 success, 1 device absent, 2 timeout/device error, 3 buffer too small, 4 unsupported response. Register offsets: ownership register 0x00, status register 0x18, burst count low byte 0x19 and high byte 0x1A, data port 0x24.

Top module: `cmdrsp_poll_seq`

## Requirements
- R1: The first bus access of an exchange is a read of offset 0x00. If it returns 0xFF, the exchange ends with code 1, rsp_len 0, and no write to offset 0x00.
- R2: The sequencer writes 0x02 to offset 0x00 and then polls offset 0x00 until bits 7 and 5 are both set. After ceil(TO_A_US/POLL_US) failed polls (10 with defaults, so 11 reads of offset 0x00 in total) it ends with code 2.
- R3: The sequencer writes 0x40 to offset 0x18 and polls offset 0x18 until bit 6 is set. On timeout (TO_B_US) it ends with code 2.
- R4: The burst count is read as offset 0x19 (low byte) followed by offset 0x1A (high byte). A zero count is polled again, up to ceil(TO_D_US/POLL_US) low-byte reads (10 by default), and then the exchange ends with code 2.
- R5: The command bytes are written to offset 0x24 in index order. No more bytes are written than the current burst count allows before the count is fetched again.
- R6: After the last command byte, offset 0x18 is polled for bit 7 = 1 and bit 3 = 0. On timeout (TO_C_US) the exchange ends with code 3.
- R7: The sequencer writes 0x20 to offset 0x18 and polls for bits 7 and 4 both set. On timeout (TO_MAX_US) it ends with code 2.
- R8: The first six bytes read from offset 0x24 are the header: a big-endian 16-bit tag in bytes 0–1, then a big-endian 32-bit total size. A tag equal to LEGACY_TAG (default 0x00C4) ends the exchange with code 4.
- R9: A header size larger than rsp_cap ends the exchange with code 3 and rsp_len 0. A size equal to rsp_cap is accepted.
- R10: On success, every response byte (the header included) is written to the response buffer at its index in arrival order. A burst count left over from the header is used before a new one is fetched. The result is code 0 with rsp_len equal to the header size.
- R11: Every exit path ends with a write of 0x40 to offset 0x18. The done pulse is high for exactly one cycle, the cycle after that write is acknowledged.
- R12: While a bus request is not yet acknowledged, its address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins one exchange |
| cmd_len | input | LEN_W | Number of command bytes |
| rsp_cap | input | LEN_W | Response buffer capacity in bytes |
| cmd_addr | output | LEN_W | Index into the command buffer |
| cmd_byte | input | 8 | Command buffer byte at cmd_addr |
| rsp_we | output | 1 | Response buffer write strobe |
| rsp_addr | output | LEN_W | Response buffer write index |
| rsp_byte | output | 8 | Response buffer write data |
| bus_req | output | 1 | Bus access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completes on this cycle |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Result code, held until the next start |
| rsp_len | output | LEN_W | Response length on success, else 0 |

## Verification
A bus access completes on the clock edge where bus_ack is high. Every status decision is made on that edge, so the done pulse, result code and length all appear one cycle after the final status write is acknowledged. The bench waits for done on falling edges and checks code, length and the last status write in that same cycle. It then checks one cycle later that done has dropped. Read counts and captured bytes, such as the number of polls before a timeout, are compared only after done, when the device model has stopped changing.

// File: rtl/cmdrsp_poll_seq.sv
module cmdrsp_poll_seq #(
  parameter int AW        = 12,
  parameter int LEN_W     = 11,
  parameter int TICK_DIV  = 4,
  parameter int POLL_US   = 2,
  parameter int TO_A_US   = 20,
  parameter int TO_B_US   = 40,
  parameter int TO_C_US   = 20,
  parameter int TO_D_US   = 20,
  parameter int TO_MAX_US = 200,
  parameter logic [15:0] LEGACY_TAG = 16'h00C4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [LEN_W-1:0] rsp_cap,
  output logic [LEN_W-1:0] cmd_addr,
  input  logic [7:0]       cmd_byte,
  output logic             rsp_we,
  output logic [LEN_W-1:0] rsp_addr,
  output logic [7:0]       rsp_byte,
  output logic             bus_req,
  output logic             bus_wr,
  output logic [AW-1:0]    bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             done,
  output logic [2:0]       err,
  output logic [LEN_W-1:0] rsp_len
);
  localparam logic [AW-1:0] OFS_OWN = AW'(12'h000);
  localparam logic [AW-1:0] OFS_STS = AW'(12'h018);
  localparam logic [AW-1:0] OFS_BCL = AW'(12'h019);
  localparam logic [AW-1:0] OFS_BCH = AW'(12'h01A);
  localparam logic [AW-1:0] OFS_DAT = AW'(12'h024);
  localparam int POLL_CYC = POLL_US * TICK_DIV;
  localparam logic [15:0] LIM_A = 16'((TO_A_US + POLL_US - 1) / POLL_US);
  localparam logic [15:0] LIM_B = 16'((TO_B_US + POLL_US - 1) / POLL_US);
  localparam logic [15:0] LIM_C = 16'((TO_C_US + POLL_US - 1) / POLL_US);
  localparam logic [15:0] LIM_D = 16'((TO_D_US + POLL_US - 1) / POLL_US);
  localparam logic [15:0] LIM_M = 16'((TO_MAX_US + POLL_US - 1) / POLL_US);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [2:0] E_OK = 3'd0, E_NF = 3'd1, E_TMO = 3'd2, E_SMALL = 3'd3, E_UNSUP = 3'd4;

  typedef enum logic [4:0] {
    IDLE, PRES, REQ, PACC, RDYW, PRDY, BCLO, BCHI, SEND,
    PEXP, GOW, PDAT, RECV, CHK, WAITP, FIN
  } st_t;
  typedef enum logic [1:0] {PH_SEND, PH_HDR, PH_BODY} ph_t;

  st_t              st, pst;
  ph_t              ph;
  logic [LEN_W-1:0] idx, tot;
  logic [15:0]      bc, npoll, lim;
  logic [$clog2(POLL_CYC+1)-1:0] wcnt;
  logic [47:0]      hdr;
  logic [15:0]      bc_new;

  assign bc_new   = {bus_rdata, bc[7:0]};
  assign cmd_addr = idx;
  assign rsp_we   = (st == RECV) && bus_ack;
  assign rsp_addr = idx;
  assign rsp_byte = bus_rdata;
  assign bus_req  = !(st inside {IDLE, CHK, WAITP});
  assign bus_wr   = st inside {REQ, RDYW, SEND, GOW, FIN};

  always_comb begin
    case (st)
      PRES, REQ, PACC: bus_addr = OFS_OWN;
      BCLO:            bus_addr = OFS_BCL;
      BCHI:            bus_addr = OFS_BCH;
      SEND, RECV:      bus_addr = OFS_DAT;
      default:         bus_addr = OFS_STS;
    endcase
    case (st)
      REQ:       bus_wdata = 8'h02;
      RDYW, FIN: bus_wdata = 8'h40;
      GOW:       bus_wdata = 8'h20;
      SEND:      bus_wdata = cmd_byte;
      default:   bus_wdata = 8'h00;
    endcase
    case (st)
      PACC:    lim = LIM_A;
      PRDY:    lim = LIM_B;
      BCHI:    lim = LIM_D;
      PEXP:    lim = LIM_C;
      default: lim = LIM_M;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; pst <= IDLE; ph <= PH_SEND;
      idx <= '0; tot <= '0; bc <= '0; npoll <= '0; wcnt <= '0;
      hdr <= '0; done <= 1'b0; err <= E_OK; rsp_len <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          idx <= '0; npoll <= '0; err <= E_OK; rsp_len <= '0; st <= PRES;
        end
        WAITP: if (wcnt == ($bits(wcnt))'(POLL_CYC - 1)) st <= pst;
               else wcnt <= wcnt + 1'b1;
        CHK: begin
          if (hdr[47:32] == LEGACY_TAG) begin
            err <= E_UNSUP; st <= FIN;
          end else if (hdr[31:0] > 32'(rsp_cap)) begin
            err <= E_SMALL; st <= FIN;
          end else if (hdr[31:0] <= 32'd6) begin
            rsp_len <= LEN_W'(hdr[31:0]); st <= FIN;
          end else begin
            tot <= LEN_W'(hdr[31:0]); ph <= PH_BODY;
            st <= (bc == 16'd0) ? BCLO : RECV;
          end
        end
        default: if (bus_ack) begin
          case (st)
            PRES: if (bus_rdata == 8'hFF) begin err <= E_NF; st <= FIN; end
                  else st <= REQ;
            REQ:  st <= PACC;
            RDYW: st <= PRDY;
            GOW:  st <= PDAT;
            BCLO: begin bc[7:0] <= bus_rdata; st <= BCHI; end
            SEND: begin
              idx <= idx + ONE; bc <= bc - 16'd1;
              if (idx + ONE == cmd_len) st <= PEXP;
              else if (bc == 16'd1) st <= BCLO;
            end
            RECV: begin
              hdr <= {hdr[39:0], bus_rdata}; idx <= idx + ONE; bc <= bc - 16'd1;
              if (ph == PH_HDR && idx == LEN_W'(5)) st <= CHK;
              else if (ph == PH_BODY && idx + ONE == tot) begin
                rsp_len <= tot; st <= FIN;
              end else if (bc == 16'd1) st <= BCLO;
            end
            FIN: begin done <= 1'b1; st <= IDLE; end
            default: begin
              if ((st == PACC && bus_rdata[7] && bus_rdata[5]) ||
                  (st == PRDY && bus_rdata[6]) ||
                  (st == BCHI && bc_new != 16'd0) ||
                  (st == PEXP && bus_rdata[7] && !bus_rdata[3]) ||
                  (st == PDAT && bus_rdata[7] && bus_rdata[4])) begin
                npoll <= '0;
                case (st)
                  PACC: st <= RDYW;
                  PRDY: begin
                    ph <= PH_SEND; idx <= '0;
                    st <= (cmd_len == '0) ? PEXP : BCLO;
                  end
                  BCHI: begin bc <= bc_new; st <= (ph == PH_SEND) ? SEND : RECV; end
                  PEXP: st <= GOW;
                  default: begin ph <= PH_HDR; idx <= '0; bc <= '0; st <= BCLO; end
                endcase
              end else if (npoll + 16'd1 >= lim) begin
                err <= (st == PEXP) ? E_SMALL : E_TMO; st <= FIN;
              end else begin
                npoll <= npoll + 16'd1; wcnt <= '0;
                pst <= (st == BCHI) ? BCLO : st; st <= WAITP;
              end
            end
          endcase
        end
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_wr && bus_ack && bus_addr == OFS_STS && bus_wdata == 8'h40));
  // R5
  send_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == OFS_DAT) |-> bc != 16'd0);
  // R9
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_OK) |-> rsp_len <= rsp_cap);
  // R1
  absent_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_NF) |-> rsp_len == '0);
  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)));
endmodule

// File: tb/tb_cmdrsp_poll_seq.sv
module tb_cmdrsp_poll_seq;
  localparam int LEN_W = 11;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0, rsp_cap = '0, cmd_addr, rsp_addr, rsp_len;
  logic [7:0] cmd_byte, rsp_byte, bus_wdata, bus_rdata;
  logic rsp_we, bus_req, bus_wr, done;
  logic bus_ack = 1'b0;
  logic [11:0] bus_addr;
  logic [2:0] err;

  always #4 clk = ~clk;

  cmdrsp_poll_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .rsp_cap(rsp_cap),
    .cmd_addr(cmd_addr), .cmd_byte(cmd_byte), .rsp_we(rsp_we), .rsp_addr(rsp_addr),
    .rsp_byte(rsp_byte), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done),
    .err(err), .rsp_len(rsp_len));

  typedef struct packed {
    logic [31:0] pres, acc_d, rdy_d, bstall;
    logic [15:0] burst;
    logic [31:0] xstuck, dat_d;
    logic [15:0] tag;
    logic [31:0] size, cap, len, eerr, elen;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'd1, 32'd2,    32'd1,    32'd0,    16'd3,     32'd0, 32'd3,     16'h8001, 32'd10, 32'd16, 32'd5, 32'd0, 32'd10},
    '{32'd1, 32'd0,    32'd0,    32'd0,    16'd1,     32'd0, 32'd0,     16'h8001, 32'd6,  32'd6,  32'd1, 32'd0, 32'd6},
    '{32'd0, 32'd0,    32'd0,    32'd0,    16'd3,     32'd0, 32'd0,     16'h8001, 32'd10, 32'd16, 32'd5, 32'd1, 32'd0},
    '{32'd1, 32'd1000, 32'd0,    32'd0,    16'd3,     32'd0, 32'd0,     16'h8001, 32'd10, 32'd16, 32'd5, 32'd2, 32'd0},
    '{32'd1, 32'd0,    32'd1000, 32'd0,    16'd3,     32'd0, 32'd0,     16'h8001, 32'd10, 32'd16, 32'd5, 32'd2, 32'd0},
    '{32'd1, 32'd0,    32'd0,    32'd1000, 16'd3,     32'd0, 32'd0,     16'h8001, 32'd10, 32'd16, 32'd5, 32'd2, 32'd0},
    '{32'd1, 32'd0,    32'd0,    32'd0,    16'd3,     32'd1, 32'd0,     16'h8001, 32'd10, 32'd16, 32'd5, 32'd3, 32'd0},
    '{32'd1, 32'd0,    32'd0,    32'd0,    16'd3,     32'd0, 32'd10000, 16'h8001, 32'd10, 32'd16, 32'd5, 32'd2, 32'd0},
    '{32'd1, 32'd0,    32'd0,    32'd0,    16'd3,     32'd0, 32'd0,     16'h00C4, 32'd10, 32'd16, 32'd5, 32'd4, 32'd0},
    '{32'd1, 32'd0,    32'd0,    32'd0,    16'd3,     32'd0, 32'd0,     16'h8001, 32'd20, 32'd12, 32'd5, 32'd3, 32'd0},
    '{32'd1, 32'd0,    32'd0,    32'd3,    16'd2,     32'd0, 32'd2,     16'h8002, 32'd13, 32'd13, 32'd7, 32'd0, 32'd13},
    '{32'd1, 32'd1,    32'd2,    32'd0,    16'h0100,  32'd0, 32'd1,     16'h8001, 32'd8,  32'd16, 32'd4, 32'd0, 32'd8}
  };

  vec_t cfg;
  int checks = 0, fails = 0;
  logic dev_clr = 1'b0;
  int own_wr, own_rd, own_polls, sts_polls, dat_polls, lo_reads, sent, rp, hold_err;
  logic own_req, rdy_wr, go, zero_now;
  logic [7:0] last_sts;
  logic [11:0] prev_addr;
  logic [7:0] sent_mem [64];
  logic [7:0] rbuf [64];

  function automatic logic [7:0] cbyte(input int i);
    return 8'((i * 5 + 1) & 8'hFF);
  endfunction
  function automatic logic [7:0] rbyte(input int i);
    case (i)
      0: return cfg.tag[15:8];
      1: return cfg.tag[7:0];
      2: return cfg.size[31:24];
      3: return cfg.size[23:16];
      4: return cfg.size[15:8];
      5: return cfg.size[7:0];
      default: return 8'((i * 7 + 3) & 8'hFF);
    endcase
  endfunction

  assign cmd_byte = cbyte(int'(cmd_addr));

  always_comb begin
    case (bus_addr)
      12'h000: bus_rdata = (cfg.pres == 0) ? 8'hFF :
                 ((own_req && own_polls >= int'(cfg.acc_d)) ? 8'hA0 : 8'h80);
      12'h018: bus_rdata = {1'b1, rdy_wr && sts_polls >= int'(cfg.rdy_d), 1'b0,
                 go && dat_polls >= int'(cfg.dat_d),
                 (cfg.xstuck != 0) || (sent < int'(cfg.len)), 3'b000};
      12'h019: bus_rdata = (lo_reads < int'(cfg.bstall)) ? 8'h00 : cfg.burst[7:0];
      12'h01A: bus_rdata = zero_now ? 8'h00 : cfg.burst[15:8];
      12'h024: bus_rdata = rbyte(rp);
      default: bus_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    if (dev_clr) begin
      own_wr <= 0; own_rd <= 0; own_polls <= 0; sts_polls <= 0; dat_polls <= 0;
      lo_reads <= 0; sent <= 0; rp <= 0; own_req <= 1'b0; rdy_wr <= 1'b0;
      go <= 1'b0; zero_now <= 1'b0; last_sts <= 8'h00; bus_ack <= 1'b0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && bus_ack) begin
        if (bus_addr != prev_addr) hold_err <= hold_err + 1;
        if (bus_wr) begin
          case (bus_addr)
            12'h000: begin own_wr <= own_wr + 1; own_req <= 1'b1; end
            12'h018: begin
              last_sts <= bus_wdata;
              if (bus_wdata == 8'h40) begin rdy_wr <= 1'b1; sts_polls <= 0; end
              if (bus_wdata == 8'h20) begin go <= 1'b1; dat_polls <= 0; end
            end
            12'h024: begin if (sent < 64) sent_mem[sent] <= bus_wdata; sent <= sent + 1; end
            default: ;
          endcase
        end else begin
          case (bus_addr)
            12'h000: begin own_rd <= own_rd + 1; if (own_req) own_polls <= own_polls + 1; end
            12'h018: begin
              if (rdy_wr) sts_polls <= sts_polls + 1;
              if (go) dat_polls <= dat_polls + 1;
            end
            12'h019: begin zero_now <= (lo_reads < int'(cfg.bstall)); lo_reads <= lo_reads + 1; end
            12'h024: rp <= rp + 1;
            default: ;
          endcase
        end
      end
    end
    if (rsp_we && rsp_addr < 64) rbuf[rsp_addr[5:0]] <= rsp_byte;
    prev_addr <= bus_addr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    int n;
    bit seen;
    cfg = VEC[i];
    cmd_len = LEN_W'(cfg.len);
    rsp_cap = LEN_W'(cfg.cap);
    @(negedge clk) dev_clr = 1'b1;
    @(negedge clk) dev_clr = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0; seen = 1'b0;
    while (!seen && n < 20000) begin
      if (done) seen = 1'b1;
      else begin @(negedge clk); n++; end
    end
    chk(seen, "R11 done seen", int'(seen), 1);
    chk(int'(err) == int'(cfg.eerr), "R1..R10 result code", int'(err), int'(cfg.eerr));
    chk(int'(rsp_len) == int'(cfg.elen), "R9/R10 rsp_len", int'(rsp_len), int'(cfg.elen));
    chk(last_sts == 8'h40, "R11 final ready write", int'(last_sts), 32'h40);
    @(negedge clk);
    chk(!done, "R11 done one cycle", int'(done), 0);
    if (cfg.eerr == 0) begin
      for (int k = 0; k < int'(cfg.len); k++)
        chk(sent_mem[k] == cbyte(k), "R5 command byte order", int'(sent_mem[k]), int'(cbyte(k)));
      for (int k = 0; k < int'(cfg.size); k++)
        chk(rbuf[k] == rbyte(k), "R10 response byte", int'(rbuf[k]), int'(rbyte(k)));
    end
  endtask

  initial begin
    hold_err = 0;
    cfg = VEC[0];
    dev_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !bus_req && err == 3'd0 && rsp_len == '0, "R11 reset state", int'(bus_req), 0);
    dev_clr = 1'b0;
    for (int i = 0; i < NV; i++) begin
      run_vec(i);
      // R1: absent device, no ownership write
      if (i == 2) chk(own_wr == 0, "R1 no ownership write", own_wr, 0);
      // R2: 1 presence read plus 10 polls
      if (i == 3) chk(own_rd == 11, "R2 poll count to timeout", own_rd, 11);
      // R3: ready poll timed out before any burst read
      if (i == 4) chk(lo_reads == 0, "R3 no burst read after ready timeout", lo_reads, 0);
      // R4: 10 low-byte reads before burst timeout
      if (i == 5) chk(lo_reads == 10, "R4 burst poll count", lo_reads, 10);
      // R6: all command bytes went out before code 3
      if (i == 6) chk(sent == 5, "R6 bytes sent before expect timeout", sent, 5);
      // R7: data-available wait timed out without response reads
      if (i == 7) chk(rp == 0, "R7 no response reads", rp, 0);
      // R8: only the header was read
      if (i == 8) chk(rp == 6, "R8 header only", rp, 6);
      // R9: oversize stops after header
      if (i == 9) chk(rp == 6, "R9 header only", rp, 6);
    end
    chk(hold_err == 0, "R12 address held until ack", hold_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule